// File: doc/BRIEF.md
# Oversampling Serial Receiver with Edge Realignment

This block receives asynchronous serial characters on a single line, one sample per clock at sixteen samples per bit time. The line is idle high. A falling edge seen while idle marks the first sample of a start bit. The receiver then numbers the sample phases 1 to 16 inside each bit and takes three samples at phases 8, 9 and 10. It accepts the start bit only if all three of those samples are low.

Each data bit takes the majority of its three samples. If the samples disagree, the noise flag is set. Falling edges that arrive while data bits are being received restart the phase count, so a transmitter running slower or faster than nominal stays aligned with the receiver. A character carries 8 or 9 data bits, least significant bit first, followed by one stop bit. The stop bit has its own noise and framing rules. The finished word and both flags are presented together with a single-cycle strobe.

Top module: `os_uart_rx`

## Requirements
- R1: The line passes through two synchronizer flops. If rx_in goes low just before rising edge 1, the stop-bit decision falls on the 154th sample (8-bit) or the 170th sample (9-bit), counting the first low sample as 1. rx_valid is then high in the cycle after rising edge 156 (8-bit) or rising edge 172 (9-bit).
- R2: Data bits arrive least significant bit first. nine_bit is captured when the start edge is detected. With nine_bit=0, rx_word[7:0] holds the 8 data bits and rx_word[8] is 0. With nine_bit=1, rx_word[8:0] holds all 9 bits.
- R3: Each data bit is the majority of its samples at phases 8, 9 and 10. If those samples disagree, rx_noise is set for the character and the word is still correct.
- R4: A start bit is accepted only if its samples at phases 8, 9 and 10 are all low. Otherwise the receiver returns to idle and reports nothing. This means a low pulse of 9 samples is ignored, and a low pulse of 10 samples followed by a high line yields the word of all ones.
- R5: The stop bit is sampled at phases 8, 9 and 10:
  - three high samples give a clean character;
  - exactly two high samples give rx_noise=1 and rx_frame=0;
  - one or no high sample gives rx_frame=1.
- R6: rx_valid is high for exactly one cycle per accepted character, with rx_word, rx_noise and rx_frame valid in that cycle. All outputs are 0 after reset.
- R7: While data bits are received, a falling edge seen at any phase other than 8, 9 or 10 marks phase 1 of a bit. Because of this, a character with alternating bits (0x55) sent with 18-sample bits is received clean.
- R8: A character with no inner edges is received clean when it is slow by 4.3% (8-bit) or 3.9% (9-bit). The same all-zero 8-bit character sent with 18-sample bits is flagged with rx_frame=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, sixteen times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| rx_word | output | MAXBITS | Received data word |
| rx_valid | output | 1 | One-cycle strobe for a finished character |
| rx_noise | output | 1 | Sample disagreement in a data bit or one low stop sample |
| rx_frame | output | 1 | Stop bit found low in two or more samples |
| | | | |

## Verification
The hardest situation to reach from the ports is a transmitter whose bit time differs from sixteen samples, since only then does phase realignment change the outcome. The bench describes each frame by a bit length in sixteenths of a sample. It computes the line value of every sample arithmetically from that length, so slow characters with and without inner edges can be sent side by side. Glitches are injected on single sample indices chosen to land on the mid-bit samples. This exercises the noise rules without creating edges that would count as valid for realignment.

// File: rtl/rxu_pkg.sv
package rxu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic       bit_val;
        logic       mixed;
        logic [1:0] ones;
    } vote_t;

    function automatic vote_t vote3(input logic [2:0] s);
        vote_t r;
        r.ones    = {1'b0, s[0]} + {1'b0, s[1]} + {1'b0, s[2]};
        r.bit_val = r.ones[1];
        r.mixed   = (r.ones != 2'd0) && (r.ones != 2'd3);
        return r;
    endfunction

endpackage

// File: rtl/rxu_sync.sv
module rxu_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign dout = chain[STAGES-1];
    assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/rxu_vote.sv
module rxu_vote #(
    parameter int PW    = 5,
    parameter int FIRST = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] ph,
    input  logic          smp,
    output rxu_pkg::vote_t v
);
    localparam int NSTORE = 2;

    logic [NSTORE-1:0] held;

    for (genvar g = 0; g < NSTORE; g++) begin : g_cap
        always_ff @(posedge clk) begin
            if (rst) begin
                held[g] <= 1'b1;
            end else if (ph == PW'(FIRST + g)) begin
                held[g] <= smp;
            end
        end
    end

    assign v = rxu_pkg::vote3({held, smp});
endmodule

// File: rtl/os_uart_rx.sv
module os_uart_rx #(
    parameter int OVS     = 16,
    parameter int MAXBITS = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_in,
    input  logic               nine_bit,
    output logic [MAXBITS-1:0] rx_word,
    output logic               rx_valid,
    output logic               rx_noise,
    output logic               rx_frame
);
    import rxu_pkg::*;

    localparam int PW  = $clog2(OVS + 1);
    localparam int MID = OVS / 2;
    localparam int DEC = MID + 2;
    localparam int IW  = $clog2(MAXBITS);

    rx_state_e          state_q;
    logic [PW-1:0]      ph_q;
    logic [IW-1:0]      idx_q;
    logic               len9_q;
    logic [MAXBITS-1:0] word_acc;
    logic               noise_acc;

    logic    line_s;
    logic    fall;
    vote_t   v;
    logic    in_win;
    logic    at_dec;
    logic [PW-1:0] ph_nxt;
    logic [IW-1:0] last_idx;

    rxu_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_in),
        .dout (line_s),
        .fall (fall)
    );

    rxu_vote #(.PW(PW), .FIRST(MID)) u_vote (
        .clk (clk),
        .rst (rst),
        .ph  (ph_q),
        .smp (line_s),
        .v   (v)
    );

    assign in_win   = (ph_q >= PW'(MID)) && (ph_q <= PW'(DEC));
    assign at_dec   = (ph_q == PW'(DEC));
    assign ph_nxt   = (ph_q == PW'(OVS)) ? PW'(1) : ph_q + PW'(1);
    assign last_idx = len9_q ? IW'(MAXBITS - 1) : IW'(MAXBITS - 2);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            ph_q      <= PW'(1);
            idx_q     <= '0;
            len9_q    <= 1'b0;
            word_acc  <= '0;
            noise_acc <= 1'b0;
            rx_word   <= '0;
            rx_valid  <= 1'b0;
            rx_noise  <= 1'b0;
            rx_frame  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (fall) begin
                        state_q   <= ST_START;
                        ph_q      <= PW'(2);
                        idx_q     <= '0;
                        len9_q    <= nine_bit;
                        word_acc  <= '0;
                        noise_acc <= 1'b0;
                    end
                end
                ST_START: begin
                    ph_q <= ph_nxt;
                    if (at_dec) begin
                        state_q <= (v.ones == 2'd0) ? ST_DATA : ST_IDLE;
                    end
                end
                ST_DATA: begin
                    if (fall && !in_win) begin
                        ph_q <= PW'(2);
                    end else begin
                        ph_q <= ph_nxt;
                    end
                    if (at_dec) begin
                        word_acc[idx_q] <= v.bit_val;
                        noise_acc       <= noise_acc | v.mixed;
                        if (idx_q == last_idx) begin
                            state_q <= ST_STOP;
                        end else begin
                            idx_q <= idx_q + IW'(1);
                        end
                    end
                end
                ST_STOP: begin
                    ph_q <= ph_nxt;
                    if (at_dec) begin
                        rx_valid <= 1'b1;
                        rx_word  <= word_acc;
                        rx_noise <= noise_acc | (v.ones == 2'd2);
                        rx_frame <= (v.ones < 2'd2);
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/os_uart_rx_chk.sv
module os_uart_rx_chk #(
    parameter int OVS     = 16,
    parameter int MAXBITS = 9
) (
    input logic                     clk,
    input logic                     rst,
    input rxu_pkg::rx_state_e       state_q,
    input logic [$clog2(OVS+1)-1:0] ph_q,
    input logic                     len9_q,
    input logic                     fall,
    input logic                     rx_valid,
    input logic [MAXBITS-1:0]       rx_word
);
    import rxu_pkg::*;

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R6
    valid_src_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(state_q) == ST_STOP);

    // R2
    short_word_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !$past(len9_q)) |-> !rx_word[MAXBITS-1]);

    // R4
    start_enter_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_START && $past(state_q) == ST_IDLE) |-> $past(fall));

    // R1
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |-> (ph_q >= 1 && ph_q <= OVS));

    // R7
    realign_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA && $past(state_q) == ST_DATA && ph_q == 2)
            |-> ($past(ph_q) == 1 || $past(fall)));
endmodule

bind os_uart_rx os_uart_rx_chk #(.OVS(OVS), .MAXBITS(MAXBITS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .state_q  (state_q),
    .ph_q     (ph_q),
    .len9_q   (len9_q),
    .fall     (fall),
    .rx_valid (rx_valid),
    .rx_word  (rx_word)
);

// File: tb/test_os_uart_rx.sv
module test_os_uart_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_in = 1'b1;
    logic       nine_bit = 1'b0;
    logic [8:0] rx_word;
    logic       rx_valid;
    logic       rx_noise;
    logic       rx_frame;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    os_uart_rx i_os_uart_rx (
        .clk      (clk),
        .rst      (rst),
        .rx_in    (rx_in),
        .nine_bit (nine_bit),
        .rx_word  (rx_word),
        .rx_valid (rx_valid),
        .rx_noise (rx_noise),
        .rx_frame (rx_frame)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            nerr = nerr + 1;
            nchk = nchk + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // pq: bit length in sixteenths of a sample; g1/g2: flipped sample indices;
    // short_lo > 0: line low for that many samples, then high
    task automatic run_frame(input logic [8:0] word, input bit n9, input int pq,
                             input int g1, input int g2, input int short_lo,
                             output int nval, output int first_k,
                             output logic [8:0] w, output logic nz, output logic fr);
        int nb;
        nval = 0; first_k = -1; w = '0; nz = 1'b0; fr = 1'b0;
        nb = n9 ? 9 : 8;
        nine_bit = n9;
        for (int k = 0; k < 240; k++) begin
            logic v;
            int   b;
            @(negedge clk);
            if (rx_valid) begin
                nval++;
                if (nval == 1) begin
                    first_k = k; w = rx_word; nz = rx_noise; fr = rx_frame;
                end
            end
            if (short_lo > 0) begin
                v = (k < short_lo) ? 1'b0 : 1'b1;
            end else begin
                b = (k * 16) / pq;
                if (b == 0)       v = 1'b0;
                else if (b <= nb) v = word[b-1];
                else              v = 1'b1;
            end
            if (k == g1 || k == g2) v = ~v;
            rx_in = v;
        end
    endtask

    task automatic expect_char(input string req, input logic [8:0] word, input bit n9,
                               input int pq, input int g1, input int g2,
                               input logic en, input logic ef, input int ek);
        int nval, fk;
        logic [8:0] w;
        logic nz, fr;
        run_frame(word, n9, pq, g1, g2, 0, nval, fk, w, nz, fr);
        chk(nval == 1, req, "strobe count", nval, 1);
        chk(w == word, req, "word", w, word);
        chk(nz == en, req, "noise", nz, en);
        chk(fr == ef, req, "frame", fr, ef);
        if (ek >= 0) chk(fk == ek, req, "strobe cycle", fk, ek);
    endtask

    initial begin
        int nval, fk;
        logic [8:0] w;
        logic nz, fr;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R6 reset state
        chk(rx_valid == 0 && rx_word == 0 && rx_noise == 0 && rx_frame == 0,
            "R6", "reset outputs", {rx_valid, rx_noise, rx_frame}, 0);
        repeat (4) @(negedge clk);

        // R1 R2: every 8-bit word at nominal rate, strobe after edge 156
        for (int d = 0; d < 256; d++)
            expect_char("R2", 9'(d), 1'b0, 256, -1, -1, 1'b0, 1'b0, 156);

        // R1 R2: 9-bit words, strobe after edge 172
        for (int d = 0; d < 512; d += 7)
            expect_char("R1", 9'(d), 1'b1, 256, -1, -1, 1'b0, 1'b0, 172);
        expect_char("R2", 9'h1FF, 1'b1, 256, -1, -1, 1'b0, 1'b0, 172);

        // R3: one disagreeing mid-bit sample in each data bit
        for (int j = 0; j < 8; j++) begin
            expect_char("R3", 9'h000, 1'b0, 256, (j+1)*16+8, -1, 1'b1, 1'b0, -1);
            expect_char("R3", 9'h0FF, 1'b0, 256, (j+1)*16+8, -1, 1'b1, 1'b0, -1);
        end
        expect_char("R3", 9'h1FF, 1'b1, 256, 9*16+7, -1, 1'b1, 1'b0, -1);

        // R5: stop bit rules (stop samples at 151..153 for 8-bit)
        expect_char("R5", 9'h03C, 1'b0, 256, 152, -1, 1'b1, 1'b0, 156);
        expect_char("R5", 9'h03C, 1'b0, 256, 153, -1, 1'b1, 1'b0, 156);
        expect_char("R5", 9'h03C, 1'b0, 256, 151, 152, 1'b0, 1'b1, 156);
        expect_char("R5", 9'h0C3, 1'b0, 256, 151, 153, 1'b0, 1'b1, 156);
        expect_char("R5", 9'h0C3, 1'b1, 256, 167, -1, 1'b1, 1'b0, 172);

        // R4: start qualification
        run_frame(9'h0, 1'b0, 256, -1, -1, 9, nval, fk, w, nz, fr);
        chk(nval == 0, "R4", "9-sample pulse strobes", nval, 0);
        run_frame(9'h0, 1'b0, 256, 7, -1, 0, nval, fk, w, nz, fr);
        chk(nval == 0, "R4", "start RT8 high strobes", nval, 0);
        run_frame(9'h0, 1'b0, 256, -1, -1, 10, nval, fk, w, nz, fr);
        chk(nval == 1, "R4", "10-sample pulse strobes", nval, 1);
        chk(w == 9'h0FF, "R4", "10-sample pulse word", w, 9'h0FF);

        // R7: realignment on inner edges with 18-sample bits
        expect_char("R7", 9'h055, 1'b0, 288, -1, -1, 1'b0, 1'b0, -1);

        // R8: tolerance without inner edges
        expect_char("R8", 9'h000, 1'b0, 267, -1, -1, 1'b0, 1'b0, -1);
        expect_char("R8", 9'h000, 1'b1, 266, -1, -1, 1'b0, 1'b0, -1);
        run_frame(9'h0, 1'b0, 288, -1, -1, 0, nval, fk, w, nz, fr);
        chk(nval == 1 && fr == 1'b1, "R8", "slow frame flag", fr, 1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule